// File: doc/BRIEF.md
# Leading-Edge Window Selector

This block sits on a stream of summed, baseline-corrected signed samples and forwards only the part of each pulse around its rising edge. Every accepted sample goes into a small circular buffer. When a sample rises strictly above a threshold, a control latch is set. The latch arms a read counter, and the counter walks the buffer. It emits a fixed burst of POST_CNT+2 samples: the one sample that came before the crossing, the crossing sample itself, and the POST_CNT samples that follow it.

While the latch is set, the comparator is masked, so the large samples inside the pulse body cannot start a second window. The latch clears together with the final sample of the burst. The threshold comes in as a plain input word. It is normally set to about a tenth of the expected pulse peak, and choosing its value is left to the surrounding system. The downstream interpolator consumes the burst, using the last flag to frame it.

Top module: `edge_window_sel`

## Requirements
- R1: While reset is held and directly after it, `out_valid` and `out_last` are 0.
- R2: A sample arms the selector only if `in_valid` is 1 and the sample, read as two's complement, is strictly greater than `thresh` read as two's complement. A sample equal to the threshold does not arm it.
- R3: An armed selector emits exactly POST_CNT+2 samples, which is 5 with the default POST_CNT of 3. They come out in arrival order, from the sample accepted just before the crossing through the POST_CNT-th sample after it.
- R4: `out_last` is 1 on the final (fifth by default) sample of a burst and 0 on every other output cycle.
- R5: Samples above the threshold that arrive while a burst is pending or being read out start no extra window, including the sample accepted on the cycle the final sample is emitted.
- R6: After a burst ends, the next qualifying sample starts a new burst.
- R7: Samples offered with `in_valid` at 0 are neither stored nor compared. When input has gaps, the burst waits for the missing samples and still carries only valid ones.
- R8: With back-to-back input, the first burst sample appears at the outputs one clock after the clock edge that accepts the crossing sample, and the following samples come on consecutive clocks.
- R9: Reset clears the buffer. If the crossing is the first sample accepted after reset, the pre-crossing sample of its burst is 0.
- R10: The comparison is signed. With a negative threshold, negative samples above it arm the selector. With a positive threshold, large negative words never arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | SAMPLE_W | Signed input sample |
| thresh | input | SAMPLE_W | Signed trigger threshold |
| out_valid | output | 1 | Burst sample valid |
| out_data | output | SAMPLE_W | Selected sample |
| out_last | output | 1 | Final sample of a burst |

## Verification
The hardest case to create is a threshold crossing that lands exactly on the clock where the latch releases. It has to be shown to be ignored, while the very next crossing is accepted. The bench reaches this with an unbroken rising ramp above a zero threshold. The ramp is timed so that one sample arrives on the release edge and a second arrives right after it. The expected second burst then starts one sample later than a naive retrigger would start it. Gapped input with large invalid words checks that the read counter stalls instead of reading stale entries.

// File: rtl/ews_pkg.sv
package ews_pkg;
  localparam int DEF_SAMPLE_W = 12;
  localparam int DEF_POST_CNT = 3;
  localparam int DEF_DEPTH    = 8;

  function automatic int win_len(input int post_cnt);
    return post_cnt + 2;
  endfunction
endpackage

// File: rtl/ews_cmp.sv
module ews_cmp #(
  parameter int W = 12
) (
  input  logic         valid,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] thr,
  output logic         hit
);
  always_comb begin
    hit = valid && ($signed(sample) > $signed(thr));
  end
endmodule

// File: rtl/ews_ring.sv
module ews_ring #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [AW-1:0] wr_ptr
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_ptr_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    always_comb slot_we = wr_en && (wr_ptr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_we) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    if (wr_en) wr_ptr_d = wr_ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr_d;
  end

  always_comb rd_data = slot_q[rd_addr];
endmodule

// File: rtl/ews_ctrl.sv
module ews_ctrl #(
  parameter int AW  = 3,
  parameter int WIN = 5,
  localparam int CW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_go,
  output logic          rd_last,
  output logic          busy
);
  logic          busy_d;
  logic [AW-1:0] rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_go   = busy && (rd_addr != wr_ptr);
    rd_last = rd_go && (cnt_q == CW'(WIN - 1));
    busy_d  = busy;
    rd_d    = rd_addr;
    cnt_d   = cnt_q;
    if (!busy) begin
      if (hit) begin
        busy_d = 1'b1;
        rd_d   = wr_ptr - AW'(1);
        cnt_d  = '0;
      end
    end else if (rd_go) begin
      rd_d  = rd_addr + AW'(1);
      cnt_d = cnt_q + CW'(1);
      if (rd_last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_addr <= '0;
      cnt_q   <= '0;
    end else begin
      busy    <= busy_d;
      rd_addr <= rd_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/edge_window_sel.sv
module edge_window_sel #(
  parameter int SAMPLE_W = ews_pkg::DEF_SAMPLE_W,
  parameter int POST_CNT = ews_pkg::DEF_POST_CNT,
  parameter int DEPTH    = ews_pkg::DEF_DEPTH,
  localparam int AW      = $clog2(DEPTH),
  localparam int WIN     = ews_pkg::win_len(POST_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] thresh,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_last
);
  logic                hit;
  logic                busy;
  logic                rd_go;
  logic                rd_last;
  logic [AW-1:0]       rd_addr;
  logic [AW-1:0]       wr_ptr;
  logic [SAMPLE_W-1:0] rd_data;
  logic [SAMPLE_W-1:0] data_d;

  ews_cmp #(.W(SAMPLE_W)) cmp_i (
    .valid  (in_valid),
    .sample (in_sample),
    .thr    (thresh),
    .hit    (hit)
  );

  ews_ring #(.W(SAMPLE_W), .DEPTH(DEPTH)) ring_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_sample),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_ptr  (wr_ptr)
  );

  ews_ctrl #(.AW(AW), .WIN(WIN)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .wr_ptr  (wr_ptr),
    .rd_addr (rd_addr),
    .rd_go   (rd_go),
    .rd_last (rd_last),
    .busy    (busy)
  );

  always_comb begin
    data_d = out_data;
    if (rd_go) data_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_go;
      out_last  <= rd_last;
      out_data  <= data_d;
    end
  end
endmodule

// File: rtl/ews_chk.sv
module ews_chk #(
  parameter int W   = 12,
  parameter int WIN = 5,
  localparam int NW = $clog2(WIN + 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_sample,
  input logic [W-1:0] thresh,
  input logic         out_valid,
  input logic         out_last,
  input logic         busy
);
  logic [NW-1:0] n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    n_out <= '0;
    else if (out_valid && out_last) n_out <= '0;
    else if (out_valid)             n_out <= n_out + NW'(1);
  end

  AST_ARM_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && ($signed(in_sample) > $signed(thresh))) |=> busy); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid); // R3
  AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (n_out == NW'(WIN - 1))); // R3
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (n_out < NW'(WIN - 1))); // R4
  AST_RELEASE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (out_valid && out_last)); // R5
endmodule

bind edge_window_sel ews_chk #(.W(SAMPLE_W), .WIN(WIN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .thresh    (thresh),
  .out_valid (out_valid),
  .out_last  (out_last),
  .busy      (busy)
);

// File: tb/edge_window_sel_tb_top.sv
module edge_window_sel_tb_top;
  localparam int W      = 12;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_sample;
  logic [W-1:0] thresh;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_last;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int obs_n = 0;
  int obs_d [32];
  int obs_l [32];
  int obs_c [32];
  bit done = 0;

  always #(CLK_PER / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_window_sel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .thresh    (thresh),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always @(negedge clk) begin
    if (out_valid && obs_n < 32) begin
      obs_d[obs_n] = int'($signed(out_data));
      obs_l[obs_n] = int'(out_last);
      obs_c[obs_n] = cyc;
      obs_n = obs_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input int s);
    @(negedge clk);
    in_valid  = v;
    in_sample = W'(s);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid  = 1'b0;
    in_sample = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    obs_n = 0;
  endtask

  task automatic chk_win(input int b, input int e0, input int e1, input int e2,
                         input int e3, input int e4, input string req);
    int e [5];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3; e[4] = e4;
    for (int i = 0; i < 5; i++) begin
      chk(obs_d[b+i] == e[i], req, obs_d[b+i], e[i]);
      chk(obs_l[b+i] == ((i == 4) ? 1 : 0), "R4", obs_l[b+i], (i == 4) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    thresh = W'(100);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1", int'(out_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1", int'(out_valid), 0);
    obs_n = 0;
  endtask

  task automatic t_basic();
    int c_cross;
    thresh = W'(100);
    obs_n = 0;
    push(1, 10); push(1, 20); push(1, 30);
    push(1, 150); c_cross = cyc;
    push(1, 160); push(1, 170); push(1, 180); push(1, 40); push(1, 50);
    idle(12);
    chk(obs_n == 5, "R3", obs_n, 5);
    chk_win(0, 30, 150, 160, 170, 180, "R3");
    chk(obs_c[0] == c_cross + 2, "R8", obs_c[0], c_cross + 2);
    chk(obs_c[4] == c_cross + 6, "R8", obs_c[4], c_cross + 6);
  endtask

  task automatic t_equal();
    thresh = W'(100);
    obs_n = 0;
    push(1, 100); push(1, 100); push(1, 99); push(1, 100);
    idle(10);
    chk(obs_n == 0, "R2", obs_n, 0);
  endtask

  task automatic t_retrigger();
    thresh = W'(0);
    obs_n = 0;
    push(1, 0);
    for (int v = 11; v <= 22; v++) push(1, v);
    idle(12);
    chk(obs_n == 10, "R5", obs_n, 10);
    chk_win(0, 0, 11, 12, 13, 14, "R5");
    chk_win(5, 16, 17, 18, 19, 20, "R6");
  endtask

  task automatic t_gaps();
    thresh = W'(50);
    obs_n = 0;
    push(0, 999); push(0, 999);
    push(1, 1); push(1, 60);
    push(0, 999); push(0, 999);
    push(1, 61); push(0, 999);
    push(1, 62); push(1, 63);
    idle(12);
    chk(obs_n == 5, "R7", obs_n, 5);
    chk_win(0, 1, 60, 61, 62, 63, "R7");
  endtask

  task automatic t_signed();
    thresh = W'(5);
    obs_n = 0;
    push(1, -2048); push(1, -1000); push(1, -1);
    idle(8);
    chk(obs_n == 0, "R10", obs_n, 0);
    thresh = W'(-5);
    push(1, -20); push(1, -3); push(1, -2); push(1, -1); push(1, 0);
    idle(12);
    chk(obs_n == 5, "R10", obs_n, 5);
    chk_win(0, -20, -3, -2, -1, 0, "R10");
  endtask

  task automatic t_first_after_reset();
    thresh = W'(10);
    do_reset();
    push(1, 50); push(1, 51); push(1, 52); push(1, 53);
    idle(12);
    chk(obs_n == 5, "R9", obs_n, 5);
    chk_win(0, 0, 50, 51, 52, 53, "R9");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_equal();
    t_retrigger();
    t_gaps();
    t_signed();
    t_first_after_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule